// File: doc/BRIEF.md
# Base and Bounds Address Translator

This block sits between a processor's load/store path and memory and turns each virtual address into a physical one. It holds three pieces of context: a relocation base, an exclusive upper limit on the virtual address, and a one-bit flag that records whether the current code runs as a user task or as privileged software.

In user mode, each request is compared against the limit. An address inside the range is relocated by adding the base, and any carry out of the top bit is dropped. An address outside the range raises a translation fault and yields no physical address. In privileged mode, the virtual address passes through unchanged and never faults.

Privileged software loads the context on a task switch through a small write port. The last write it makes is usually the one that enters user mode. A write attempted from user mode changes nothing and raises a one-cycle privilege-violation pulse. Results come out of a single register stage, one clock after the request.

Top module: `bb_xlate_top`

## Requirements
- R1: A synchronous active-high reset selects privileged mode, clears base and limit to zero, and drives `rsp_valid`, `rsp_fault`, `rsp_paddr` and `priv_fault` low.
- R2: `rsp_valid` equals `req_valid` from one clock earlier. When `rsp_valid` is low, `rsp_paddr` and `rsp_fault` are zero.
- R3: In privileged mode (`user_mode` = 0), `rsp_paddr` equals the request's virtual address.
- R4: In user mode, an in-range request gives `rsp_paddr` = virtual address + base, modulo 2^32.
- R5: In user mode, a virtual address greater than or equal to the limit sets `rsp_fault` and forces `rsp_paddr` to zero. The address limit-1 is in range. A limit of zero faults every address.
- R6: A privileged write stores `wr_data` according to `wr_sel`: 0 writes the base, 1 writes the limit, 2 writes the mode from `wr_data[0]` (1 = user, 0 = privileged), and 3 has no effect. The new value applies to requests made from the next cycle on.
- R7: A write attempted in user mode leaves base, limit and mode unchanged. It sets `priv_fault` high in the following cycle only.
- R8: A request made in privileged mode never faults, whatever the limit value.
- R9: `user_mode` reflects the stored mode flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address of the request |
| wr_en | input | 1 | Context write strobe |
| wr_sel | input | 2 | Context field select (0 base, 1 limit, 2 mode, 3 none) |
| wr_data | input | 32 | Context write value |
| rsp_valid | output | 1 | Translation result valid, one cycle after the request |
| rsp_paddr | output | 32 | Physical address (zero on fault or when idle) |
| rsp_fault | output | 1 | Out-of-range fault for the responding request |
| priv_fault | output | 1 | One-cycle pulse after a write attempted in user mode |
| user_mode | output | 1 | Current mode flag (1 = user) |

## Verification
Every translation result (`rsp_valid`, `rsp_paddr`, `rsp_fault`) is due on the first rising edge after the request is presented. A `priv_fault` pulse is due on the first edge after the rejected write and must be gone one edge later. A context write changes translation only for requests made on or after the following edge.

The bench drives stimulus on the falling edge and samples on the next falling edge, so each check falls exactly one register stage after its cause. Context writes are always completed a full cycle before the request that depends on them.

// File: rtl/bb_xlate_pkg.sv
package bb_xlate_pkg;

    localparam int unsigned XW    = 32;
    localparam int unsigned SEL_W = 2;

    typedef logic [XW-1:0] xaddr_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_BASE  = 2'd0,
        SEL_LIMIT = 2'd1,
        SEL_MODE  = 2'd2,
        SEL_NONE  = 2'd3
    } ctx_sel_e;

    // Translation context: mode flag plus relocation pair
    typedef struct packed {
        logic   user;
        xaddr_t base;
        xaddr_t limit;
    } ctx_t;

    typedef struct packed {
        logic   valid;
        logic   fault;
        xaddr_t paddr;
    } xresp_t;

    // Unsigned limit test: out of range when vaddr >= limit
    function automatic logic out_of_range(xaddr_t vaddr, xaddr_t limit);
        return vaddr >= limit;
    endfunction

    // Relocation; result width drops the carry
    function automatic xaddr_t relocate(xaddr_t vaddr, xaddr_t base);
        xaddr_t sum;
        sum = vaddr + base;
        return sum;
    endfunction

endpackage

// File: rtl/bb_ctx_regs.sv
module bb_ctx_regs
    import bb_xlate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  xaddr_t           wr_data,
    output ctx_t             ctx,
    output logic             priv_fault
);

    logic wr_ok;
    logic wr_bad;

    assign wr_ok  = wr_en && !ctx.user;
    assign wr_bad = wr_en &&  ctx.user;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx        <= '0;
            priv_fault <= 1'b0;
        end else begin
            priv_fault <= wr_bad;
            if (wr_ok) begin
                case (ctx_sel_e'(wr_sel))
                    SEL_BASE:  ctx.base  <= wr_data;
                    SEL_LIMIT: ctx.limit <= wr_data;
                    SEL_MODE:  ctx.user  <= wr_data[0];
                    default:   ;
                endcase
            end
        end
    end

    // A user-mode write must not disturb any context field
    assert_user_write_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        wr_bad |=> ($stable(ctx.base) && $stable(ctx.limit) && ctx.user));

    assert_priv_fault_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        wr_bad |=> priv_fault);

    assert_priv_fault_cause_R7: assert property (@(posedge clk) disable iff (rst)
        !wr_bad |=> !priv_fault);

endmodule

// File: rtl/bb_xlate_calc.sv
module bb_xlate_calc
    import bb_xlate_pkg::*;
(
    input  ctx_t   ctx,
    input  logic   req_valid,
    input  xaddr_t req_vaddr,
    output xresp_t nxt
);

    logic   over;
    xaddr_t moved;

    // Limit compare and relocation add run side by side
    assign over  = ctx.user && out_of_range(req_vaddr, ctx.limit);
    assign moved = relocate(req_vaddr, ctx.base);

    always_comb begin
        nxt.valid = req_valid;
        nxt.fault = req_valid && over;
        if (!req_valid || over)
            nxt.paddr = '0;
        else if (ctx.user)
            nxt.paddr = moved;
        else
            nxt.paddr = req_vaddr;
    end

endmodule

// File: rtl/bb_resp_stage.sv
module bb_resp_stage
    import bb_xlate_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  xresp_t nxt,
    input  logic   user_in,
    output xresp_t rsp
);

    always_ff @(posedge clk) begin
        if (rst) rsp <= '0;
        else     rsp <= nxt;
    end

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
        nxt.valid |=> rsp.valid);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !nxt.valid |=> (!rsp.valid && !rsp.fault && rsp.paddr == '0));

    assert_priv_no_fault_R8: assert property (@(posedge clk) disable iff (rst)
        !user_in |=> !rsp.fault);

    assert_fault_zero_addr_R5: assert property (@(posedge clk) disable iff (rst)
        rsp.fault |-> (rsp.paddr == '0 && rsp.valid));

endmodule

// File: rtl/bb_xlate_top.sv
module bb_xlate_top
    import bb_xlate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [XW-1:0]    req_vaddr,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [XW-1:0]    wr_data,
    output logic             rsp_valid,
    output logic [XW-1:0]    rsp_paddr,
    output logic             rsp_fault,
    output logic             priv_fault,
    output logic             user_mode
);

    ctx_t   ctx;
    xresp_t nxt;
    xresp_t rsp;

    bb_ctx_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .ctx        (ctx),
        .priv_fault (priv_fault)
    );

    bb_xlate_calc u_calc (
        .ctx       (ctx),
        .req_valid (req_valid),
        .req_vaddr (req_vaddr),
        .nxt       (nxt)
    );

    bb_resp_stage u_resp (
        .clk     (clk),
        .rst     (rst),
        .nxt     (nxt),
        .user_in (ctx.user),
        .rsp     (rsp)
    );

    assign rsp_valid = rsp.valid;
    assign rsp_paddr = rsp.paddr;
    assign rsp_fault = rsp.fault;
    assign user_mode = ctx.user;

    assert_passthrough_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !user_mode) |=> (rsp_paddr == $past(req_vaddr)));

    assert_limit_fault_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && user_mode && req_vaddr >= ctx.limit) |=> rsp_fault);

endmodule

// File: tb/bb_xlate_top_bench.sv
module bb_xlate_top_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [31:0] req_vaddr;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [31:0] wr_data;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic        priv_fault;
    logic        user_mode;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    bb_xlate_top u_bb_xlate_top (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_vaddr  (req_vaddr),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .rsp_valid  (rsp_valid),
        .rsp_paddr  (rsp_paddr),
        .rsp_fault  (rsp_fault),
        .priv_fault (priv_fault),
        .user_mode  (user_mode)
    );

    // {vaddr, expected paddr, expected fault} with base F000_0000, limit 0001_0000
    localparam logic [64:0] VEC [6] = '{
        {32'h0000_0000, 32'hF000_0000, 1'b0},
        {32'h0000_1234, 32'hF000_1234, 1'b0},
        {32'h0000_8000, 32'hF000_8000, 1'b0},
        {32'h0000_FFFF, 32'hF000_FFFF, 1'b0},
        {32'h0001_0000, 32'h0000_0000, 1'b1},
        {32'hFFFF_FFFF, 32'h0000_0000, 1'b1}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        req_valid = 1'b0; req_vaddr = '0;
        wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // Called at a falling edge; returns at the falling edge where the result is due
    task automatic xlate(input logic [31:0] va, input logic [31:0] exp_pa,
                         input logic exp_f, input string tag);
        req_valid = 1'b1; req_vaddr = va;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " valid"}, {31'd0, rsp_valid}, 32'd1);
        check({tag, " paddr"}, rsp_paddr, exp_pa);
        check({tag, " fault"}, {31'd0, rsp_fault}, {31'd0, exp_f});
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R1 rsp_paddr", rsp_paddr, 32'd0);
        check("R1 priv_fault", {31'd0, priv_fault}, 32'd0);
        check("R1 user_mode", {31'd0, user_mode}, 32'd0);

        // R3 / R8: privileged passthrough, zero limit does not fault
        xlate(32'h1234_5678, 32'h1234_5678, 1'b0, "R3 passthrough");
        xlate(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R8 zero limit");
        // R2: idle cycle
        @(negedge clk);
        check("R2 idle valid", {31'd0, rsp_valid}, 32'd0);
        check("R2 idle paddr", rsp_paddr, 32'd0);

        // R6: privileged loads, reserved select ignored
        wr(2'd1, 32'h0000_0010);
        check("R6 no priv fault", {31'd0, priv_fault}, 32'd0);
        xlate(32'h0000_0100, 32'h0000_0100, 1'b0, "R8 above limit");
        wr(2'd0, 32'hF000_0000);
        wr(2'd1, 32'h0001_0000);
        wr(2'd3, 32'h0000_0001);
        check("R6 sel3 mode untouched", {31'd0, user_mode}, 32'd0);
        xlate(32'h0000_0040, 32'h0000_0040, 1'b0, "R6 still privileged");
        wr(2'd2, 32'h0000_0001);
        check("R9 user_mode", {31'd0, user_mode}, 32'd1);

        // R4 / R5: table walk in user mode
        for (int i = 0; i < 6; i++) begin
            xlate(VEC[i][64:33], VEC[i][32:1], VEC[i][0], "R4R5 table");
        end

        // R7: user writes rejected
        wr(2'd0, 32'h0000_0000);
        check("R7 priv_fault high", {31'd0, priv_fault}, 32'd1);
        @(negedge clk);
        check("R7 priv_fault one cycle", {31'd0, priv_fault}, 32'd0);
        xlate(32'h0000_1234, 32'hF000_1234, 1'b0, "R7 base kept");
        wr(2'd1, 32'hFFFF_FFFF);
        xlate(32'h0001_0000, 32'h0000_0000, 1'b1, "R7 limit kept");
        wr(2'd2, 32'h0000_0000);
        check("R7 mode kept", {31'd0, user_mode}, 32'd1);

        // R1: second reset clears context
        do_reset();
        check("R1 mode cleared", {31'd0, user_mode}, 32'd0);
        wr(2'd2, 32'h0000_0001);
        xlate(32'h0000_0000, 32'h0000_0000, 1'b1, "R5 zero limit");

        // R4: wrap modulo 2^32, R5: address equal to limit
        do_reset();
        wr(2'd0, 32'h8000_0000);
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd2, 32'h0000_0001);
        xlate(32'h9000_0000, 32'h1000_0000, 1'b0, "R4 wrap");
        xlate(32'hFFFF_FFFE, 32'h7FFF_FFFE, 1'b0, "R5 limit-1");
        xlate(32'hFFFF_FFFF, 32'h0000_0000, 1'b1, "R5 equal limit");
        @(negedge clk);
        check("R2 idle after fault", {31'd0, rsp_fault}, 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule